// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block watches three digitized supply comparator flags and turns them into the actions a processor subsystem needs as power degrades and returns. The flags report whether the supply is above the warning level, above the minimum operating level, and above the backup battery level. These levels are ordered: warning is highest, then minimum, then battery. Every flag passes through a synchronizer and a debounce filter before it can change the sequencer state.

When the supply falls below the warning level, the block raises an interrupt request with vector 8'h2B, provided the warning enable is set. The processor keeps running while the warning is active. Below the minimum level, the block holds the processor in reset and forces the external memory bus strobes inactive. The top address bit keeps its last value during this time, and the other address bits are driven low. Below the battery level, the block selects the battery as the memory supply. When the supply recovers, the block waits out a fixed power-on delay, counted in clock cycles, before it releases reset.

Top module: `pfail_seq`

## Requirements
- R1: While rstN is low and after it is released with all three flags low, cpuReset=1, battSelect=1, warnIrq=0 and irqVector=8'h00.
- R2: Each flag goes through a SYNC_STAGES-flop synchronizer and must hold a new value for DEB_CYCLES consecutive cycles before it is accepted. A pulse shorter than DEB_CYCLES has no effect on any output.
- R3: When aboveWarn falls while warnEnable=1, warnIrq rises and irqVector reads 8'h2B. cpuReset stays 0.
- R4: If warnEnable=0 when the warning state is entered, warnIrq stays 0.
- R5: Once warnIrq is set, it stays set until irqAck is pulsed or aboveWarn returns high.
- R6: While aboveMin is low, cpuReset is held at 1.
- R7: While cpuReset=1, memCe1N, memCe2N and memRwN are all 1. At other times they follow coreCe1N, coreCe2N and coreRwN.
- R8: While cpuReset=1, memAddr[ADDR_W-1] keeps the value coreAddr[ADDR_W-1] had in the last cycle before reset, and memAddr[ADDR_W-2:0] is 0. At other times memAddr follows coreAddr.
- R9: While aboveBatt is low, battSelect=1 (and cpuReset=1). When aboveBatt returns high, battSelect goes back to 0.
- R10: After the filtered aboveMin flag rises, cpuReset stays 1 for POR_CYCLES (default 21504) clock cycles and then falls.
- R11: If aboveMin drops during the power-on wait, the delay count restarts from zero on the next recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aboveWarn | input | 1 | Supply above warning level |
| aboveMin | input | 1 | Supply above minimum operating level |
| aboveBatt | input | 1 | Supply above battery level |
| warnEnable | input | 1 | Enables the warning interrupt |
| irqAck | input | 1 | Core acknowledge of the warning interrupt |
| coreCe1N | input | 1 | Core chip enable 1, active low |
| coreCe2N | input | 1 | Core chip enable 2, active low |
| coreRwN | input | 1 | Core read/write strobe, low means write |
| coreAddr | input | ADDR_W | Core memory address |
| warnIrq | output | 1 | Warning interrupt request, level held |
| irqVector | output | 8 | 8'h2B while warnIrq is set, otherwise 0 |
| cpuReset | output | 1 | Processor reset |
| battSelect | output | 1 | Memory supply taken from the battery |
| memCe1N | output | 1 | Gated chip enable 1 |
| memCe2N | output | 1 | Gated chip enable 2 |
| memRwN | output | 1 | Gated read/write strobe |
| memAddr | output | ADDR_W | Gated address with retained top bit |

## Verification
The assertions assume that irqAck comes only from a core that is out of reset. They also assume the comparator flags respect the threshold order in steady state, so that aboveMin is never high while aboveBatt is low for longer than the debounce window. The stimulus keeps to these assumptions. It lowers flags from the top threshold down and raises them from the bottom up, and it confines random activity (warning toggles, enable flips, acknowledges, bus values) to periods when the minimum and battery flags are high. Deliberate glitches stay shorter than the debounce window.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_WARN,
    ST_RESET,
    ST_BACKUP,
    ST_PORWAIT
  } supState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic porClr;
    logic porRun;
    logic warnSet;
    logic warnClr;
  } dpCtl_t;

  localparam logic [7:0] WARN_VECTOR = 8'h2B;

  // flag positions in the filtered flag vector
  localparam int FLG_BATT = 0;
  localparam int FLG_MIN  = 1;
  localparam int FLG_WARN = 2;
  localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/pfail_dp.sv
module pfail_dp
  import pfail_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4,
  parameter int POR_CYCLES  = 21504
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] rawFlags,
  input  dpCtl_t               ctl,
  input  logic                 warnEnable,
  input  logic                 irqAck,
  output logic [NUM_FLAGS-1:0] filtFlags,
  output logic                 porDone,
  output logic                 warnIrq
);

  localparam int DEB_W = $clog2(DEB_CYCLES + 1);
  localparam int POR_W = $clog2(POR_CYCLES + 1);

  // synchronizer and debounce, one lane per flag
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gLane
    logic [SYNC_STAGES-1:0] syncSh;
    logic [DEB_W-1:0]       debCnt;
    logic                   syncQ;

    assign syncQ = syncSh[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncSh       <= '0;
        debCnt       <= '0;
        filtFlags[i] <= 1'b0;
      end else begin
        syncSh <= {syncSh[SYNC_STAGES-2:0], rawFlags[i]};
        if (syncQ == filtFlags[i]) begin
          debCnt <= '0;
        end else if (debCnt == DEB_W'(DEB_CYCLES - 1)) begin
          debCnt       <= '0;
          filtFlags[i] <= syncQ;
        end else begin
          debCnt <= debCnt + 1'b1;
        end
      end
    end
  end

  // power-on delay counter
  logic [POR_W-1:0] porCnt;

  assign porDone = ctl.porRun && (porCnt == POR_W'(POR_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      porCnt <= '0;
    else if (ctl.porClr)            porCnt <= '0;
    else if (ctl.porRun && !porDone) porCnt <= porCnt + 1'b1;
  end

  // warning interrupt request, level held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            warnIrq <= 1'b0;
    else if (ctl.warnSet && warnEnable)   warnIrq <= 1'b1;
    else if (irqAck || ctl.warnClr)       warnIrq <= 1'b0;
  end

  AST_POR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    porCnt < POR_W'(POR_CYCLES)); // R10

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warnIrq) |-> $past(warnEnable)); // R4

  AST_IRQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (warnIrq && irqAck && !ctl.warnSet) |=> !warnIrq); // R5

endmodule

// File: rtl/pfail_ctrl.sv
module pfail_ctrl
  import pfail_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] filtFlags,
  input  logic                 porDone,
  output dpCtl_t               ctl,
  output logic                 cpuReset,
  output logic                 battSelect
);

  supState_t state, nxt;

  logic fBatt, fMin, fWarn;
  assign fBatt = filtFlags[FLG_BATT];
  assign fMin  = filtFlags[FLG_MIN];
  assign fWarn = filtFlags[FLG_WARN];

  // lowest threshold wins
  always_comb begin
    nxt = state;
    if (!fBatt) begin
      nxt = ST_BACKUP;
    end else if (!fMin) begin
      nxt = ST_RESET;
    end else begin
      case (state)
        ST_BACKUP:  nxt = ST_RESET;
        ST_RESET:   nxt = ST_PORWAIT;
        ST_PORWAIT: if (porDone) nxt = fWarn ? ST_NORMAL : ST_WARN;
        ST_NORMAL:  if (!fWarn) nxt = ST_WARN;
        ST_WARN:    if (fWarn) nxt = ST_NORMAL;
        default:    nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_BACKUP;
    else       state <= nxt;
  end

  always_comb begin
    ctl.porClr  = (nxt == ST_PORWAIT) && (state != ST_PORWAIT);
    ctl.porRun  = (state == ST_PORWAIT);
    ctl.warnSet = (nxt == ST_WARN) && (state != ST_WARN);
    ctl.warnClr = (state == ST_WARN) && (nxt != ST_WARN);
  end

  assign cpuReset   = (state == ST_RESET) || (state == ST_BACKUP) || (state == ST_PORWAIT);
  assign battSelect = (state == ST_BACKUP);

  AST_POR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuReset) |-> $past(porDone)); // R10

  AST_MIN_LOW_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (!fMin && $past(!fMin)) |-> cpuReset); // R6

endmodule

// File: rtl/pfail_seq.sv
module pfail_seq
  import pfail_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4,
  parameter int POR_CYCLES  = 21504,
  parameter int ADDR_W      = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aboveWarn,
  input  logic              aboveMin,
  input  logic              aboveBatt,
  input  logic              warnEnable,
  input  logic              irqAck,
  input  logic              coreCe1N,
  input  logic              coreCe2N,
  input  logic              coreRwN,
  input  logic [ADDR_W-1:0] coreAddr,
  output logic              warnIrq,
  output logic [7:0]        irqVector,
  output logic              cpuReset,
  output logic              battSelect,
  output logic              memCe1N,
  output logic              memCe2N,
  output logic              memRwN,
  output logic [ADDR_W-1:0] memAddr
);

  logic [NUM_FLAGS-1:0] rawFlags, filtFlags;
  dpCtl_t               ctl;
  logic                 porDone;
  logic                 addrHold;

  always_comb begin
    rawFlags           = '0;
    rawFlags[FLG_BATT] = aboveBatt;
    rawFlags[FLG_MIN]  = aboveMin;
    rawFlags[FLG_WARN] = aboveWarn;
  end

  pfail_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_CYCLES (DEB_CYCLES),
    .POR_CYCLES (POR_CYCLES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .rawFlags  (rawFlags),
    .ctl       (ctl),
    .warnEnable(warnEnable),
    .irqAck    (irqAck),
    .filtFlags (filtFlags),
    .porDone   (porDone),
    .warnIrq   (warnIrq)
  );

  pfail_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .filtFlags (filtFlags),
    .porDone   (porDone),
    .ctl       (ctl),
    .cpuReset  (cpuReset),
    .battSelect(battSelect)
  );

  // retained top address bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          addrHold <= 1'b0;
    else if (!cpuReset) addrHold <= coreAddr[ADDR_W-1];
  end

  assign irqVector = warnIrq ? WARN_VECTOR : 8'h00;
  assign memCe1N   = coreCe1N | cpuReset;
  assign memCe2N   = coreCe2N | cpuReset;
  assign memRwN    = coreRwN  | cpuReset;
  assign memAddr   = cpuReset ? {addrHold, {(ADDR_W-1){1'b0}}} : coreAddr;

  AST_BUS_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReset |-> (memCe1N && memCe2N && memRwN)); // R7

  AST_ADDR_RETAINED: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReset && $past(cpuReset)) |-> $stable(memAddr[ADDR_W-1])); // R8

  AST_WARN_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    warnIrq |-> !cpuReset); // R3

  AST_BATT_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    battSelect |-> cpuReset); // R9

endmodule

// File: tb/sim_pfail_seq.sv
`timescale 1ns/1ps
module sim_pfail_seq;

  localparam int ADDR_W = 15;
  localparam int POR    = 21504;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aboveWarn = 1'b0, aboveMin = 1'b0, aboveBatt = 1'b0;
  logic warnEnable = 1'b1, irqAck = 1'b0;
  logic coreCe1N = 1'b0, coreCe2N = 1'b0, coreRwN = 1'b0;
  logic [ADDR_W-1:0] coreAddr = '0;
  logic warnIrq, cpuReset, battSelect, memCe1N, memCe2N, memRwN;
  logic [7:0] irqVector;
  logic [ADDR_W-1:0] memAddr;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  pfail_seq u0 (
    .clk(clk), .rstN(rstN), .aboveWarn(aboveWarn), .aboveMin(aboveMin),
    .aboveBatt(aboveBatt), .warnEnable(warnEnable), .irqAck(irqAck),
    .coreCe1N(coreCe1N), .coreCe2N(coreCe2N), .coreRwN(coreRwN),
    .coreAddr(coreAddr), .warnIrq(warnIrq), .irqVector(irqVector),
    .cpuReset(cpuReset), .battSelect(battSelect), .memCe1N(memCe1N),
    .memCe2N(memCe2N), .memRwN(memRwN), .memAddr(memAddr)
  );

  function automatic logic [ADDR_W+2:0] expBus(input logic rst, input logic hold);
    if (rst) return {3'b111, hold, {(ADDR_W-1){1'b0}}};
    return {coreCe1N, coreCe2N, coreRwN, coreAddr};
  endfunction

  function automatic logic [7:0] expVec(input logic irq);
    return irq ? 8'h2B : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      finishRun();
    end
  end

  initial begin
    logic expIrq;
    void'($urandom(32'd4242));
    waitc(5);
    // R1: reset state
    chk("R1 cpuReset in reset", cpuReset, 1);
    rstN = 1'b1;
    waitc(1);
    chk("R1 cpuReset", cpuReset, 1);
    chk("R1 battSelect", battSelect, 1);
    chk("R1 warnIrq", warnIrq, 0);
    chk("R1 irqVector", irqVector, 0);
    chk("R7 bus forced at start", {memCe1N, memCe2N, memRwN}, 3'b111);

    // R9: battery flag up leaves backup, still in reset
    aboveBatt = 1'b1;
    waitc(SETTLE);
    chk("R9 battSelect off", battSelect, 0);
    chk("R6 still reset", cpuReset, 1);

    // R10: power-on delay
    aboveMin = 1'b1; aboveWarn = 1'b1;
    waitc(POR - SETTLE);
    chk("R10 reset held before delay", cpuReset, 1);
    waitc(40);
    chk("R10 reset released", cpuReset, 0);
    chk("R4 no irq after power up", warnIrq, 0);

    // R7 pass-through
    coreCe1N = 1'b0; coreCe2N = 1'b1; coreRwN = 1'b0; coreAddr = 15'h5A5A;
    waitc(1);
    chk("R7 R8 pass-through", {memCe1N, memCe2N, memRwN, memAddr}, expBus(1'b0, 1'b0));

    // R2 glitches
    aboveMin = 1'b0; waitc(2); aboveMin = 1'b1;
    waitc(SETTLE);
    chk("R2 min glitch ignored", cpuReset, 0);
    aboveWarn = 1'b0; waitc(2); aboveWarn = 1'b1;
    waitc(SETTLE);
    chk("R2 warn glitch ignored", warnIrq, 0);

    // R3, R5 ack
    aboveWarn = 1'b0;
    waitc(SETTLE);
    chk("R3 irq raised", warnIrq, 1);
    chk("R3 vector", irqVector, 8'h2B);
    chk("R3 core keeps running", cpuReset, 0);
    waitc(30);
    chk("R5 irq held", warnIrq, 1);
    irqAck = 1'b1; waitc(1); irqAck = 1'b0;
    waitc(2);
    chk("R5 ack clears", warnIrq, 0);
    aboveWarn = 1'b1; waitc(SETTLE);

    // R4 disabled
    warnEnable = 1'b0; aboveWarn = 1'b0;
    waitc(SETTLE);
    chk("R4 disabled no irq", warnIrq, 0);
    aboveWarn = 1'b1; waitc(SETTLE);
    warnEnable = 1'b1; aboveWarn = 1'b0;
    waitc(SETTLE);
    chk("R3 irq again", warnIrq, 1);
    aboveWarn = 1'b1;
    waitc(SETTLE);
    chk("R5 recovery clears", warnIrq, 0);

    // random phase, supply above minimum
    expIrq = 1'b0;
    for (int i = 0; i < 200; i++) begin
      int act;
      act = $urandom % 4;
      case (act)
        0: begin
          if (aboveWarn) expIrq = warnEnable;
          else           expIrq = 1'b0;
          aboveWarn = ~aboveWarn;
        end
        1: warnEnable = ~warnEnable;
        2: begin irqAck = 1'b1; waitc(1); irqAck = 1'b0; expIrq = 1'b0; end
        default: ;
      endcase
      coreCe1N = 1'($urandom); coreCe2N = 1'($urandom); coreRwN = 1'($urandom);
      coreAddr = ADDR_W'($urandom);
      waitc(SETTLE);
      chk("R3 R5 random irq", warnIrq, expIrq);
      chk("R3 random vector", irqVector, expVec(expIrq));
      chk("R7 R8 random bus", {memCe1N, memCe2N, memRwN, memAddr}, expBus(1'b0, 1'b0));
    end
    aboveWarn = 1'b1; warnEnable = 1'b1;
    waitc(SETTLE);

    // R6 R7 R8 min drop
    coreAddr = 15'h7123; coreCe1N = 1'b0; coreCe2N = 1'b0; coreRwN = 1'b0;
    waitc(1);
    aboveWarn = 1'b0; aboveMin = 1'b0;
    waitc(SETTLE);
    chk("R6 reset on min drop", cpuReset, 1);
    chk("R7 R8 forced bus", {memCe1N, memCe2N, memRwN, memAddr}, expBus(1'b1, 1'b1));
    coreAddr = 15'h0000;
    waitc(5);
    chk("R8 top bit retained", memAddr, 15'h4000);
    chk("R9 no backup above batt", battSelect, 0);

    // R11 restart
    aboveMin = 1'b1; aboveWarn = 1'b1;
    waitc(10000);
    chk("R10 in delay", cpuReset, 1);
    aboveMin = 1'b0; waitc(20); aboveMin = 1'b1;
    waitc(POR - SETTLE);
    chk("R11 delay restarted", cpuReset, 1);
    waitc(40);
    chk("R11 released after restart", cpuReset, 0);

    // R9 backup
    aboveWarn = 1'b0; waitc(2); aboveMin = 1'b0; waitc(2); aboveBatt = 1'b0;
    waitc(SETTLE);
    chk("R9 battSelect on", battSelect, 1);
    chk("R9 reset in backup", cpuReset, 1);
    chk("R7 forced in backup", {memCe1N, memCe2N, memRwN}, 3'b111);
    aboveBatt = 1'b1;
    waitc(SETTLE);
    chk("R9 battSelect back off", battSelect, 0);
    chk("R6 reset after backup", cpuReset, 1);
    aboveMin = 1'b1; aboveWarn = 1'b1;
    waitc(POR + 24);
    chk("R10 release after backup", cpuReset, 0);

    finishRun();
  end

endmodule